// File: doc/BRIEF.md
# Regulator Protection Fault Supervisor

This block is the digital protection manager of a single-phase voltage regulator. It receives four comparator flags from the analog front end: a moderate overcurrent flag, a hard-short flag (load far beyond the trip level), an undervoltage flag and an overvoltage flag. It filters each flag in time and combines them into a single fault latch. While the latch is set, the power-good output and both gate-drive enables are held low.

Overcurrent is filtered by an up/down counter. The counter is sampled on a periodic tick, so brief overloads leak away and a sustained overload trips. A separate fast path catches hard shorts within a few microseconds. Under- and overvoltage each pass through their own continuous-persistence timer. All intervals are derived from the `CLK_HZ` parameter. The latch is cleared only by dropping the enable input or by the power-on reset. A 2-bit cause code records which kind of fault latched first.

All five asynchronous inputs go through two-flop synchronizers. The block has no data stream: every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `reg_fault_supervisor`

## Requirements
- R1: While `rst_n` is low, `pgood`, `hs_en`, `ls_en` and `fault` are 0 and `fault_cause` is 0. Reset clears any latched fault.
- R2: The overcurrent counter is updated once per tick (`TICK_NS`, default 15 us). On each tick it adds one if the synchronized overcurrent flag is high and subtracts one if it is low, so interleaved overload and idle periods cancel.
- R3: An overcurrent fault latches when the counter reaches `OC_TRIP` (default 8). A continuously held flag therefore trips after about `OC_TRIP` ticks and not before `OC_TRIP-1` ticks.
- R4: The overcurrent counter stops at zero on decrement and never wraps, so a long idle period does not shorten or lengthen the next trip.
- R5: A hard-short flag held high latches an overcurrent fault (cause 1) within `SHORT_NS` (default 2 us) of the input rising, counting the synchronizer delay, without waiting for the counter.
- R6: An undervoltage fault (cause 2) latches once the undervoltage flag has stayed high continuously for `PERSIST_NS` (default 1 ms). Shorter pulses have no effect.
- R7: An overvoltage fault (cause 3) latches once the overvoltage flag has stayed high continuously for `PERSIST_NS`. Shorter pulses have no effect.
- R8: Each persistence timer restarts from zero whenever its flag drops, so two sub-threshold pulses separated by a gap never add up to a fault.
- R9: While `fault` is 1, `pgood`, `hs_en` and `ls_en` are 0.
- R10: Once set, `fault` stays 1 while the enable stays high, even after every flag has dropped. It clears only when the enable goes low or reset is asserted.
- R11: `fault_cause` encodes 0 = none, 1 = overcurrent or hard short, 2 = undervoltage, 3 = overvoltage. It keeps the first cause until the latch clears. If several causes qualify in the same cycle, overcurrent wins over undervoltage, and undervoltage wins over overvoltage.
- R12: With the enable high and no fault, `pgood`, `hs_en` and `ls_en` are 1 within 3 clocks. With the enable low they are 0 and no fault can latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en | input | 1 | Regulator enable (asynchronous); low clears the fault latch |
| oc_flag | input | 1 | Overcurrent comparator flag (asynchronous) |
| short_flag | input | 1 | Hard-short comparator flag (asynchronous) |
| uv_flag | input | 1 | Undervoltage comparator flag (asynchronous) |
| ov_flag | input | 1 | Overvoltage comparator flag (asynchronous) |
| pgood | output | 1 | Power-good indication |
| hs_en | output | 1 | High-side gate-drive enable |
| ls_en | output | 1 | Low-side gate-drive enable |
| fault | output | 1 | Fault latch state |
| fault_cause | output | 2 | First fault cause: 0 none, 1 OC, 2 UV, 3 OV |

## Verification
The bench goes after the edges of each filter.

- **Leaky counter.** Overload bursts alternate with idle bursts. A counter that never decrements would trip on the accumulated total.
- **Floor at zero.** A long idle period is followed by a hold just short of the trip count. A counter that wraps below zero would trip at the wrong point.
- **Persistence timers.** Pulses are kept just under one millisecond, in pairs separated by a single-cycle gap. A timer that fails to restart would add the two pulses together and latch.
- **Latch and cause code.** The bench drops every flag after a trip and raises a second, different flag. A latch that follows its inputs would release, and a cause register that re-captures would change value.

Random pulse lengths drawn clearly above or below the threshold are scored against a bench prediction of the outcome.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OC   = 2'd1,
    CAUSE_UV   = 2'd2,
    CAUSE_OV   = 2'd3
  } cause_e;

  // Number of clock cycles in a span of nanoseconds, at least 1.
  function automatic int span_cycles(input longint hz, input longint ns);
    longint c;
    c = (hz * ns) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta, hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        hold <= 1'b0;
      end else begin
        meta <= d[i];
        hold <= meta;
      end
    end
    assign q[i] = hold;
  end
endmodule

// File: rtl/rfs_persist.sv
// Continuous-persistence qualifier: hit while flag has been high LIMIT cycles.
module rfs_persist #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flag,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !flag)   cnt <= '0;
    else if (cnt != LAST)    cnt <= cnt + 1'b1;
  end

  assign hit = flag && !clr && (cnt == LAST);

  // R8: a dropped flag restarts the timer
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> (cnt == '0));
endmodule

// File: rtl/rfs_oc_bucket.sv
// Tick-sampled up/down overcurrent counter with a floor at zero.
module rfs_oc_bucket #(
  parameter int TICK_CYC = 1500,
  parameter int TRIP     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic oc,
  output logic trip
);
  localparam int TW = (TICK_CYC < 2) ? 1 : $clog2(TICK_CYC);
  localparam int LW = $clog2(TRIP + 1);
  localparam logic [TW-1:0] TLAST = TW'(TICK_CYC - 1);
  localparam logic [LW-1:0] LTOP  = LW'(TRIP);

  logic [TW-1:0] tcnt;
  logic [LW-1:0] lvl;
  logic          tick;

  assign tick = (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tcnt <= '0;
    else if (clr)   tcnt <= '0;
    else if (tick)  tcnt <= '0;
    else            tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lvl <= '0;
    else if (clr)             lvl <= '0;
    else if (tick) begin
      if (oc && lvl != LTOP)  lvl <= lvl + 1'b1;
      else if (!oc && lvl != '0) lvl <= lvl - 1'b1;
    end
  end

  assign trip = !clr && tick && oc && (lvl == LTOP - 1'b1);

  // R4: decrement at zero keeps zero
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && !oc && lvl == '0) |=> (lvl == '0));
  // R3: level never passes the trip count
  a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LTOP);
  // R2: level only moves on a tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(lvl));
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import rfs_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint TICK_NS    = 15_000,
  parameter longint SHORT_NS   = 2_000,
  parameter longint PERSIST_NS = 1_000_000,
  parameter int     OC_TRIP    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       oc_flag,
  input  logic       short_flag,
  input  logic       uv_flag,
  input  logic       ov_flag,
  output logic       pgood,
  output logic       hs_en,
  output logic       ls_en,
  output logic       fault,
  output logic [1:0] fault_cause
);
  localparam int TICK_CYC    = span_cycles(CLK_HZ, TICK_NS);
  localparam int SHORT_CYC   = span_cycles(CLK_HZ, SHORT_NS);
  localparam int PERSIST_CYC = span_cycles(CLK_HZ, PERSIST_NS);
  // two synchronizer cycles are spent before the short qualifier sees the flag
  localparam int SHORT_LIM   = (SHORT_CYC > 3) ? SHORT_CYC - 2 : 1;

  logic [4:0] raw, syn;
  logic en_s, oc_s, sh_s, uv_s, ov_s;
  logic clr, oc_hit, sh_hit, uv_hit, ov_hit;

  assign raw = {en, oc_flag, short_flag, uv_flag, ov_flag};

  rfs_sync #(.WIDTH(5)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign {en_s, oc_s, sh_s, uv_s, ov_s} = syn;
  assign clr = !en_s;

  rfs_oc_bucket #(.TICK_CYC(TICK_CYC), .TRIP(OC_TRIP)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .oc(oc_s), .trip(oc_hit));

  rfs_persist #(.LIMIT(SHORT_LIM)) u_short (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flag(sh_s), .hit(sh_hit));
  rfs_persist #(.LIMIT(PERSIST_CYC)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flag(uv_s), .hit(uv_hit));
  rfs_persist #(.LIMIT(PERSIST_CYC)) u_ov (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flag(ov_s), .hit(ov_hit));

  logic   fault_q, fault_d, run_q;
  cause_e cause_q, cause_d;

  always_comb begin
    fault_d = fault_q;
    cause_d = cause_q;
    if (clr) begin
      fault_d = 1'b0;
      cause_d = CAUSE_NONE;
    end else if (!fault_q) begin
      if (oc_hit || sh_hit) begin
        fault_d = 1'b1;
        cause_d = CAUSE_OC;
      end else if (uv_hit) begin
        fault_d = 1'b1;
        cause_d = CAUSE_UV;
      end else if (ov_hit) begin
        fault_d = 1'b1;
        cause_d = CAUSE_OV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      run_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      cause_q <= cause_d;
      run_q   <= en_s && !fault_d;
    end
  end

  assign pgood       = run_q;
  assign hs_en       = run_q;
  assign ls_en       = run_q;
  assign fault       = fault_q;
  assign fault_cause = cause_q;

  // R9: outputs are off while latched
  a_r9_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (!pgood && !hs_en && !ls_en));
  // R10: latch holds while enabled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && en_s) |=> fault_q);
  // R11: first cause is kept
  a_r11_cause_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && en_s) |=> $stable(cause_q));
  // R11: a latched fault always carries a cause
  a_r11_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (cause_q != CAUSE_NONE));
  // R12: nothing latches while disabled
  a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !fault_q);
endmodule

// File: tb/tb_reg_fault_supervisor.sv
module tb_reg_fault_supervisor;
  // Time base scaled down (CLK_HZ = 4 MHz) so millisecond windows stay short.
  localparam longint HZ   = 4_000_000;
  localparam int     TICK = 60;    // 15 us
  localparam int     SHRT = 8;     // 2 us
  localparam int     PERS = 4000;  // 1 ms

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0;
  logic oc = 1'b0, sh = 1'b0, uv = 1'b0, ov = 1'b0;
  logic pgood, hs_en, ls_en, fault;
  logic [1:0] cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reg_fault_supervisor #(.CLK_HZ(HZ)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc), .short_flag(sh),
    .uv_flag(uv), .ov_flag(ov), .pgood(pgood), .hs_en(hs_en), .ls_en(ls_en),
    .fault(fault), .fault_cause(cause));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected outcome of a single pulse on a persistence-filtered flag
  function automatic int exp_latch(input int dur);
    return (dur >= PERS + 2) ? 1 : 0;
  endfunction

  function automatic int outs();
    return {29'd0, pgood, hs_en, ls_en};
  endfunction

  task automatic rearm();
    oc = 0; sh = 0; uv = 0; ov = 0;
    en = 0; step(5);
    en = 1; step(5);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk("R1 reset outputs", outs(), 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset cause", cause, 0);
    rst_n = 1; step(2);
    chk("R12 disabled outputs", outs(), 0);
    en = 1; step(5);
    chk("R12 enabled outputs", outs(), 7);

    // R6/R8: two sub-threshold UV pulses split by one cycle
    uv = 1; step(PERS - 20); uv = 0; step(1);
    uv = 1; step(PERS - 20); uv = 0; step(5);
    chk("R8 split UV pulses", fault, 0);
    uv = 1; step(PERS + 20);
    chk("R6 UV latch", fault, 1);
    chk("R11 UV cause", cause, 2);
    chk("R9 outputs off", outs(), 0);
    uv = 0; ov = 1; step(PERS + 100);
    chk("R10 latch holds", fault, 1);
    chk("R11 first cause kept", cause, 2);
    ov = 0; en = 0; step(5);
    chk("R10 clear on disable", fault, 0);
    chk("R11 cleared cause", cause, 0);
    rearm();

    // R7
    ov = 1; step(PERS - 20); ov = 0; step(5);
    chk("R7 short OV ignored", fault, 0);
    ov = 1; step(PERS + 20);
    chk("R7 OV latch", cause, 3);
    rearm();

    // R11 simultaneous UV and OV
    uv = 1; ov = 1; step(PERS + 20);
    chk("R11 UV beats OV", cause, 2);
    rearm();

    // R5 hard short within 2 us
    sh = 1; step(SHRT);
    chk("R5 short latch", fault, 1);
    chk("R5 short cause", cause, 1);
    rearm();

    // R2 leaky: bursts cancel
    oc = 1; step(5 * TICK); oc = 0; step(6 * TICK);
    oc = 1; step(5 * TICK); oc = 0; step(5);
    chk("R2 leaky bursts", fault, 0);
    // R4 floor then R3 trip
    step(20 * TICK);
    oc = 1; step(6 * TICK);
    chk("R4 no early trip", fault, 0);
    step(4 * TICK);
    chk("R3 OC trip", fault, 1);
    chk("R3 OC cause", cause, 1);
    rearm();

    // random pulses on UV/OV, scored by exp_latch
    for (int i = 0; i < 14; i++) begin
      int dur, which, e;
      which = $urandom_range(1, 0);
      dur = ($urandom_range(1, 0) == 1) ? $urandom_range(PERS + 500, PERS + 10)
                                        : $urandom_range(PERS - 10, 1);
      e = exp_latch(dur);
      if (which == 0) uv = 1; else ov = 1;
      step(dur); uv = 0; ov = 0; step(5);
      chk(which == 0 ? "R6 random UV" : "R7 random OV", fault, e);
      chk("R11 random cause", cause, e == 0 ? 0 : (which == 0 ? 2 : 3));
      if (fault) rearm(); else step($urandom_range(200, 2));
    end

    // R1 reset clears a latched fault
    sh = 1; step(SHRT + 2); sh = 0;
    rst_n = 0; step(2);
    chk("R1 reset clears fault", fault, 0);
    chk("R1 reset clears cause", cause, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule